// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment choice and an effective offset into a 20-bit physical address, the way a 16-bit processor does in real address mode. It keeps four 16-bit segment registers: a code segment, a stack segment and two data segments. A write port reloads any of them at any time. The physical base of a segment is its register value times sixteen. The block adds a 16-bit offset to that base and truncates the sum to 20 bits.

Each request carries a base-register choice with its value, an index-register choice with its value, and a displacement that is either 8 or 16 bits wide. The block sums these modulo 65536 to form the offset. The segment comes from a default rule that looks at the base choice, unless the request carries a valid override. Requests enter on a valid/ready handshake. Results leave one cycle later on a registered valid/ready output. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the output holds and `req_ready` stays low, so back-pressure reaches the requester with no extra storage.

Top module: `rm_addr_gen`

## Requirements
- R1: After reset the code segment register (select code 0) holds FFFFh, the stack (1), first data (2) and second data (3) registers hold 0000h, and `out_valid` is low.
- R2: `out_addr` equals (segment value × 16 + offset) modulo 2^20, where the segment value is the one picked for that request.
- R3: The offset is (base term + index term + displacement) modulo 65536. The base term is `req_base_val` when `req_base_sel` is 1 (BX), 2 (BP) or 3 (SP), and 0 when it is 0. The index term is `req_index_val` when `req_index_sel` is 1 (SI) or 2 (DI), and 0 when it is 0 or 3.
- R4: When `req_disp_wide` is 0, only bits 7:0 of `req_disp` count, sign-extended from bit 7, and bits 15:8 have no effect. When it is 1, all 16 bits count.
- R5: Without an override, a request whose base select is 2 (BP) or 3 (SP) uses the stack segment (1). Every other request uses the first data segment (2). `out_seg` reports the segment used.
- R6: When `req_ovr_valid` is 1, the segment coded on `req_ovr_seg` replaces the default, and `out_seg` reports it.
- R7: A segment write on `seg_wr_en` lands on the next rising edge. A request accepted on that same edge still uses the old value. The first request accepted after it uses the new value.
- R8: A request accepted on a rising edge shows up on `out_valid`/`out_addr` right after that edge. `out_valid` is low when no result is pending.
- R9: While `out_valid` is high and `out_ready` is low, `out_addr` and `out_seg` hold their values and `req_ready` is low.
- R10: A sum past FFFFFh wraps into low memory. For example, segment FFFFh with offset 0020h gives 00010h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment to write: 0 code, 1 stack, 2 data0, 3 data1 |
| seg_wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_base_sel | input | 2 | Base register: 0 none, 1 BX, 2 BP, 3 SP |
| req_base_val | input | 16 | Value of the chosen base register |
| req_index_sel | input | 2 | Index register: 0 none, 1 SI, 2 DI, 3 none |
| req_index_val | input | 16 | Value of the chosen index register |
| req_disp | input | 16 | Displacement |
| req_disp_wide | input | 1 | 1: 16-bit displacement; 0: 8-bit, sign-extended |
| req_ovr_valid | input | 1 | Segment override present |
| req_ovr_seg | input | 2 | Override segment code |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 20 | Physical address |
| out_seg | output | 2 | Segment code used |

## Verification
The bench reads every segment register back through overrides with a zero offset. This shows the reset values, and it shows the edge on which a write takes effect compared with a request on that same edge. Directed offsets set the base, index and displacement terms one at a time. Carries past 16 bits and past 20 bits then show whether the wrap happens at the offset, at the address, or at both. Base choices BX, BP, SP and none, each with and without an override, separate the default-segment rule from the override path. Short displacements with bit 7 set and junk in the upper byte catch a missing sign extension. A long random run with ready gaps and segment writes mixed in exercises back-pressure holding against the reference queue.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_STACK = 2'd1,
    SEG_DATA0 = 2'd2,
    SEG_DATA1 = 2'd3
  } seg_id_e;

  typedef enum logic [1:0] {
    BASE_NONE = 2'd0,
    BASE_BX   = 2'd1,
    BASE_BP   = 2'd2,
    BASE_SP   = 2'd3
  } base_id_e;

  typedef enum logic [1:0] {
    IDX_NONE = 2'd0,
    IDX_SI   = 2'd1,
    IDX_DI   = 2'd2,
    IDX_RSVD = 2'd3
  } index_id_e;

  localparam int unsigned SEG_COUNT = 4;

endpackage

// File: rtl/rm_seg_file.sv
module rm_seg_file #(
  parameter int unsigned SEG_W    = 16,
  parameter int unsigned NUM_SEG  = 4,
  parameter logic [SEG_W-1:0] CODE_RST = '1,
  localparam int unsigned SEL_W   = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [SEG_W-1:0] rd_data
);

  logic [SEG_W-1:0] seg_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL = (g == 0) ? CODE_RST : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        seg_q[g] <= RST_VAL;
      else if (wr_en && (wr_sel == SEL_W'(g)))
        seg_q[g] <= wr_data;
    end
  end

  assign rd_data = seg_q[rd_sel];

endmodule

// File: rtl/rm_offset_calc.sv
module rm_offset_calc
  import rm_addr_pkg::*;
#(
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned SHORT_W = 8
) (
  input  base_id_e         base_sel,
  input  logic [OFF_W-1:0] base_val,
  input  index_id_e        index_sel,
  input  logic [OFF_W-1:0] index_val,
  input  logic [OFF_W-1:0] disp,
  input  logic             disp_wide,
  input  logic             ovr_valid,
  input  seg_id_e          ovr_seg,
  output logic [OFF_W-1:0] offset,
  output seg_id_e          seg_sel
);

  logic [OFF_W-1:0] base_term;
  logic [OFF_W-1:0] index_term;
  logic [OFF_W-1:0] disp_term;
  logic             stack_based;

  always_comb begin
    base_term   = (base_sel == BASE_NONE) ? '0 : base_val;
    index_term  = (index_sel == IDX_SI || index_sel == IDX_DI) ? index_val : '0;
    disp_term   = disp_wide ? disp
                            : {{(OFF_W-SHORT_W){disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
    // modulo 2^OFF_W by truncation of the sum
    offset      = base_term + index_term + disp_term;
    stack_based = (base_sel == BASE_BP) || (base_sel == BASE_SP);
    if (ovr_valid)
      seg_sel = ovr_seg;
    else if (stack_based)
      seg_sel = SEG_STACK;
    else
      seg_sel = SEG_DATA0;
  end

endmodule

// File: rtl/rm_addr_stage.sv
module rm_addr_stage
  import rm_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SHIFT = 4,
  localparam int unsigned ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  offset,
  input  seg_id_e           seg_id,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output seg_id_e           out_seg
);

  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] sum_addr;

  assign base_addr = {seg_val, {SHIFT{1'b0}}};
  assign sum_addr  = base_addr + {{(ADDR_W-OFF_W){1'b0}}, offset};
  assign in_ready  = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_seg   <= SEG_CODE;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_addr  <= sum_addr;
      out_seg   <= seg_id;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen
  import rm_addr_pkg::*;
#(
  parameter int unsigned SEG_W   = 16,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned SHIFT   = 4,
  parameter int unsigned SHORT_W = 8,
  parameter logic [SEG_W-1:0] CODE_RST = 16'hFFFF,
  localparam int unsigned ADDR_W = SEG_W + SHIFT,
  localparam int unsigned SEL_W  = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [SEL_W-1:0]  seg_wr_sel,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_base_sel,
  input  logic [OFF_W-1:0]  req_base_val,
  input  logic [1:0]        req_index_sel,
  input  logic [OFF_W-1:0]  req_index_val,
  input  logic [OFF_W-1:0]  req_disp,
  input  logic              req_disp_wide,
  input  logic              req_ovr_valid,
  input  logic [SEL_W-1:0]  req_ovr_seg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [SEL_W-1:0]  out_seg
);

  logic [OFF_W-1:0] offset;
  seg_id_e          seg_pick;
  seg_id_e          seg_out_e;
  logic [SEG_W-1:0] seg_val;

  rm_offset_calc #(.OFF_W(OFF_W), .SHORT_W(SHORT_W)) u_off (
    .base_sel  (base_id_e'(req_base_sel)),
    .base_val  (req_base_val),
    .index_sel (index_id_e'(req_index_sel)),
    .index_val (req_index_val),
    .disp      (req_disp),
    .disp_wide (req_disp_wide),
    .ovr_valid (req_ovr_valid),
    .ovr_seg   (seg_id_e'(req_ovr_seg)),
    .offset    (offset),
    .seg_sel   (seg_pick)
  );

  rm_seg_file #(.SEG_W(SEG_W), .NUM_SEG(SEG_COUNT), .CODE_RST(CODE_RST)) u_segs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_sel  (seg_wr_sel),
    .wr_data (seg_wr_data),
    .rd_sel  (seg_pick),
    .rd_data (seg_val)
  );

  rm_addr_stage #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .seg_val   (seg_val),
    .offset    (offset),
    .seg_id    (seg_pick),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_seg   (seg_out_e)
  );

  assign out_seg = seg_out_e;

endmodule

// File: rtl/rm_addr_gen_chk.sv
module rm_addr_gen_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_base_sel,
  input logic              req_ovr_valid,
  input logic [1:0]        req_ovr_seg,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        out_seg
);

  logic accept;
  assign accept = req_valid && req_ready;

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !(out_valid && !out_ready)) |=> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_seg)));

  assert_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_ovr_valid) |=> (out_seg == $past(req_ovr_seg)));

  assert_stack_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_ovr_valid && req_base_sel[1]) |=> (out_seg == 2'd1));

  assert_data_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_ovr_valid && !req_base_sel[1]) |=> (out_seg == 2'd2));

endmodule

bind rm_addr_gen rm_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_base_sel  (req_base_sel),
  .req_ovr_valid (req_ovr_valid),
  .req_ovr_seg   (req_ovr_seg),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_addr      (out_addr),
  .out_seg       (out_seg)
);

// File: tb/rm_addr_gen_tb.sv
module rm_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_sel = '0;
  logic [15:0] seg_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_base_sel = '0;
  logic [15:0] req_base_val = '0;
  logic [1:0]  req_index_sel = '0;
  logic [15:0] req_index_val = '0;
  logic [15:0] req_disp = '0;
  logic        req_disp_wide = 1'b1;
  logic        req_ovr_valid = 1'b0;
  logic [1:0]  req_ovr_seg = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [19:0] out_addr;
  logic [1:0]  out_seg;

  always #10 clk = ~clk;

  rm_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base_sel(req_base_sel), .req_base_val(req_base_val),
    .req_index_sel(req_index_sel), .req_index_val(req_index_val),
    .req_disp(req_disp), .req_disp_wide(req_disp_wide),
    .req_ovr_valid(req_ovr_valid), .req_ovr_seg(req_ovr_seg),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_seg(out_seg)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req = "R1";
  int    segm [4];
  int    q_addr [$];
  int    q_seg  [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int ref_seg();
    if (req_ovr_valid) return int'(req_ovr_seg);
    if (req_base_sel == 2'd2 || req_base_sel == 2'd3) return 1;
    return 2;
  endfunction

  function automatic int ref_addr(input int s);
    int b, x, d, off;
    b = (req_base_sel == 2'd0) ? 0 : int'(req_base_val);
    x = (req_index_sel == 2'd1 || req_index_sel == 2'd2) ? int'(req_index_val) : 0;
    if (req_disp_wide) d = int'(req_disp);
    else d = (req_disp[7:0] >= 8'h80) ? int'(req_disp[7:0]) - 256 : int'(req_disp[7:0]);
    off = (b + x + d) & 32'hFFFF;
    return (segm[s] * 16 + off) % (1 << 20);
  endfunction

  task automatic step();
    bit acc, pop;
    int s;
    #1;
    chk(out_valid == (q_addr.size() > 0), "R8", "out_valid", int'(out_valid),
        int'(q_addr.size() > 0));
    if (out_valid && q_addr.size() > 0) begin
      chk(int'(out_addr) == q_addr[0], cur_req, "out_addr", int'(out_addr), q_addr[0]);
      chk(int'(out_seg) == q_seg[0], cur_req, "out_seg", int'(out_seg), q_seg[0]);
    end
    chk(req_ready == !(q_addr.size() > 0 && !out_ready), "R9", "req_ready",
        int'(req_ready), int'(!(q_addr.size() > 0 && !out_ready)));
    acc = req_valid && req_ready;
    pop = out_valid && out_ready;
    if (pop && q_addr.size() > 0) begin
      void'(q_addr.pop_front());
      void'(q_seg.pop_front());
    end
    if (acc) begin
      s = ref_seg();
      q_addr.push_back(ref_addr(s));
      q_seg.push_back(s);
    end
    if (seg_wr_en) segm[seg_wr_sel] = int'(seg_wr_data);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] bs, input logic [15:0] bv,
                       input logic [1:0] is, input logic [15:0] iv,
                       input logic [15:0] d, input logic w,
                       input logic ov, input logic [1:0] os);
    req_valid = 1'b1;
    req_base_sel = bs; req_base_val = bv;
    req_index_sel = is; req_index_val = iv;
    req_disp = d; req_disp_wide = w;
    req_ovr_valid = ov; req_ovr_seg = os;
    step();
    req_valid = 1'b0;
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    seg_wr_en = 1'b1; seg_wr_sel = s; seg_wr_data = v;
    step();
    seg_wr_en = 1'b0;
  endtask

  task automatic drain();
    out_ready = 1'b1;
    req_valid = 1'b0;
    repeat (3) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    segm[0] = 32'hFFFF; segm[1] = 0; segm[2] = 0; segm[3] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values read back through overrides, zero offset
    cur_req = "R1";
    #1 chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    @(negedge clk);
    for (int s = 0; s < 4; s++) issue(2'd0, 16'h0, 2'd0, 16'h0, 16'h0, 1'b1, 1'b1, 2'(s));
    drain();

    // R7: write and request on the same edge, then request again
    cur_req = "R7";
    seg_wr_en = 1'b1; seg_wr_sel = 2'd2; seg_wr_data = 16'h1234;
    issue(2'd0, 16'h0, 2'd0, 16'h0, 16'h0, 1'b1, 1'b1, 2'd2);
    seg_wr_en = 1'b0;
    issue(2'd0, 16'h0, 2'd0, 16'h0, 16'h0, 1'b1, 1'b1, 2'd2);
    drain();

    // R2, R3: each offset term alone and together
    cur_req = "R2";
    issue(2'd1, 16'h1000, 2'd0, 16'h0, 16'h0, 1'b1, 1'b0, 2'd0);
    issue(2'd0, 16'h0, 2'd1, 16'h0020, 16'h0, 1'b1, 1'b0, 2'd0);
    cur_req = "R3";
    issue(2'd1, 16'h1000, 2'd2, 16'h0020, 16'h0004, 1'b1, 1'b0, 2'd0);
    issue(2'd1, 16'hFFFF, 2'd1, 16'h0002, 16'h0, 1'b1, 1'b0, 2'd0);
    issue(2'd0, 16'h5555, 2'd3, 16'h7777, 16'h0001, 1'b1, 1'b0, 2'd0);
    drain();

    // R10: wrap above 1 MB using code segment FFFFh
    cur_req = "R10";
    issue(2'd0, 16'h0, 2'd0, 16'h0, 16'h0020, 1'b1, 1'b1, 2'd0);
    wr_seg(2'd3, 16'hF800);
    issue(2'd1, 16'hF000, 2'd1, 16'h9000, 16'h0, 1'b1, 1'b1, 2'd3);
    drain();

    // R4: short displacement sign extension, upper byte ignored
    cur_req = "R4";
    issue(2'd1, 16'h0100, 2'd0, 16'h0, 16'h12F0, 1'b0, 1'b0, 2'd0);
    issue(2'd1, 16'h0100, 2'd0, 16'h0, 16'hAB7F, 1'b0, 1'b0, 2'd0);
    issue(2'd1, 16'h0100, 2'd0, 16'h0, 16'h12F0, 1'b1, 1'b0, 2'd0);
    drain();

    // R5: default segment per base choice
    cur_req = "R5";
    wr_seg(2'd1, 16'h2000);
    for (int b = 0; b < 4; b++) issue(2'(b), 16'h0010, 2'd0, 16'h0, 16'h0, 1'b1, 1'b0, 2'd0);
    drain();

    // R6: override beats the default
    cur_req = "R6";
    issue(2'd2, 16'h0010, 2'd0, 16'h0, 16'h0, 1'b1, 1'b1, 2'd3);
    issue(2'd1, 16'h0010, 2'd0, 16'h0, 16'h0, 1'b1, 1'b1, 2'd1);
    issue(2'd3, 16'h0010, 2'd1, 16'h1, 16'h0, 1'b1, 1'b1, 2'd0);
    drain();

    // R9: stall with a pending result and a waiting request
    cur_req = "R9";
    issue(2'd1, 16'h0ABC, 2'd0, 16'h0, 16'h0, 1'b1, 1'b0, 2'd0);
    out_ready = 1'b0;
    req_valid = 1'b1; req_base_val = 16'h0DEF;
    repeat (4) step();
    out_ready = 1'b1;
    step();
    req_valid = 1'b0;
    drain();

    // random mix: R2 R3 R4 R5 R6 R7 R9
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      req_valid     = ($urandom % 10) < 7;
      req_base_sel  = 2'($urandom);
      req_base_val  = 16'($urandom);
      req_index_sel = 2'($urandom);
      req_index_val = 16'($urandom);
      req_disp      = 16'($urandom);
      req_disp_wide = 1'($urandom);
      req_ovr_valid = ($urandom % 4) == 0;
      req_ovr_seg   = 2'($urandom);
      out_ready     = ($urandom % 4) != 0;
      seg_wr_en     = ($urandom % 8) == 0;
      seg_wr_sel    = 2'($urandom);
      seg_wr_data   = 16'($urandom);
      step();
    end
    seg_wr_en = 1'b0;
    drain();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule